// File: doc/BRIEF.md
# Per-Timeslot Output Tristate Controller

This block decides, for every bit of a serial time-division-multiplexed output, whether the data pin is driven or left at high impedance. It keeps one 4-bit control entry per timeslot. Each entry bit covers one quarter of the 8-bit slot, so a slot can be driven in full, in part, or not at all. An external slot/bit counter names the current slot and bit. A strobe marks each bit boundary. The registered output enable changes only on those boundaries.

A host reaches the control memory through a simple register-style port. Each write or read touches one entry and keeps the block busy for one cycle. A bulk-clear command walks the whole memory and writes zero into every entry, which keeps every slot quiet. This sweep always holds the busy flag for a fixed 1035 cycles. The memory is not touched by reset, so software runs the sweep once after power-up. A global driver-enable input forces the output enable low whatever the entries hold. Requests that arrive while the block is busy are dropped and raise a sticky error flag.

Top module: `ts_oe_ctrl`

## Requirements
- R1: With `drv_en` high and a strobed bit index b (0 = first bit of the slot), `pin_oe` takes entry bit (3 - b/2) of the current slot's entry. Entry bit 3 covers bits 0-1, bit 2 covers bits 2-3, bit 1 covers bits 4-5, and bit 0 covers bits 6-7.
- R2: An entry of 4'b0000 keeps `pin_oe` low for all eight bits of its slot. An entry of 4'b1111 keeps it high for all eight.
- R3: Asserting `rst_n` low leaves every control entry unchanged. Only `host_rdata`, `busy`, `err` and `pin_oe` return to 0.
- R4: A `cmd_clear` accepted while not busy raises `busy` on the next cycle. `busy` stays high for exactly 1035 cycles. Afterwards every entry reads 4'b0000.
- R5: While `drv_en` is low, `pin_oe` is 0 from the next clock edge on, whatever the entries, strobe or counters are.
- R6: A `host_wr`, `host_rd` or `cmd_clear` sampled while `busy` is high has no effect on the memory or `host_rdata`. It sets `err`, which stays 1 until reset.
- R7: With `drv_en` high, `pin_oe` changes only on clock edges where `bit_strobe` is high.
- R8: An accepted single write or read holds `busy` for exactly one cycle. A read presents the entry on `host_rdata` by the time `busy` falls, and `host_rdata` holds it until the next accepted read. A written value reads back unchanged.
- R9: When requests coincide in one idle cycle, `cmd_clear` wins over `host_wr`, and `host_wr` wins over `host_rd`. The losing requests are dropped without setting `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface reference clock |
| rst_n | input | 1 | Synchronous active-low reset (control memory excluded) |
| host_wr | input | 1 | Single-entry write request |
| host_rd | input | 1 | Single-entry read request |
| host_addr | input | 5 | Entry address for host access |
| host_wdata | input | 4 | Entry value to write |
| host_rdata | output | 4 | Last entry read |
| cmd_clear | input | 1 | Bulk clear command |
| busy | output | 1 | Host access or clear sweep in progress |
| err | output | 1 | Sticky flag: request arrived while busy |
| drv_en | input | 1 | Global output driver enable |
| slot_idx | input | 5 | Current timeslot from the frame counter |
| bit_idx | input | 3 | Current bit within the slot, 0 first |
| bit_strobe | input | 1 | Bit boundary marker |
| pin_oe | output | 1 | Output enable for the data pin, 1 = drive |

## Verification
A wrong entry in the control memory shows up as a wrong `pin_oe` one cycle after the strobe for that slot's quarter. It also shows up as a wrong `host_rdata` one cycle after a read of that entry. A sweep counter that stops one cycle early or late changes the length of the `busy` pulse, and the bench measures that length to the cycle. A sequencer that leaves the busy state too early or too late is caught by the one-cycle `busy` check on every host access. Dropped-request handling is seen through the `err` flag and by reading the addressed entry back after the busy period.

// File: rtl/ts_oe_pkg.sv
// Package: shared types for the per-timeslot output enable controller.
// Assumes nothing beyond the importing modules' parameters.
package ts_oe_pkg;

    // Host/sweep sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACC   = 2'd1,
        ST_SWEEP = 2'd2
    } seq_state_e;

endpackage

// File: rtl/ts_ctl_mem.sv
// Control memory: one ENTRY_W-bit entry per timeslot, one write port and
// two asynchronous read ports (host side and output side).
// Assumes: contents are deliberately NOT reset; software clears them with
// the bulk sweep. Writes take effect at the clock edge where we is high.
module ts_ctl_mem #(
    parameter int DEPTH   = 32,
    parameter int ENTRY_W = 4,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               we,
    input  logic [AW-1:0]      waddr,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [AW-1:0]      raddr_a,
    output logic [ENTRY_W-1:0] rdata_a,
    input  logic [AW-1:0]      raddr_b,
    output logic [ENTRY_W-1:0] rdata_b
);

    logic [ENTRY_W-1:0] cells [DEPTH];

    // Storage write; no reset so entries survive a hardware reset.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Host-side read port.
    assign rdata_a = cells[raddr_a];
    // Output-side read port.
    assign rdata_b = cells[raddr_b];

endmodule

// File: rtl/ts_seq.sv
// Sequencer: accepts single host writes/reads and the bulk clear command,
// runs the fixed-length clear sweep, drives busy and the sticky error flag.
// Assumes INIT_CYCLES >= DEPTH so the sweep reaches every entry.
module ts_seq
    import ts_oe_pkg::*;
#(
    parameter int DEPTH       = 32,
    parameter int ENTRY_W     = 4,
    parameter int INIT_CYCLES = 1035,
    localparam int AW         = $clog2(DEPTH),
    localparam int CW         = $clog2(INIT_CYCLES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [AW-1:0]      host_addr,
    input  logic [ENTRY_W-1:0] host_wdata,
    input  logic               cmd_clear,
    input  logic [ENTRY_W-1:0] mem_rdata,
    output logic               mem_we,
    output logic [AW-1:0]      mem_waddr,
    output logic [ENTRY_W-1:0] mem_wdata,
    output logic [ENTRY_W-1:0] host_rdata,
    output logic               busy,
    output logic               err
);

    localparam logic [CW-1:0] LAST_CNT  = CW'(INIT_CYCLES - 1);
    localparam logic [CW-1:0] DEPTH_CNT = CW'(DEPTH);

    seq_state_e      state_q;
    logic [CW-1:0]   cnt_q;
    logic            idle;
    logic            sweep_we;

    assign idle     = (state_q == ST_IDLE);
    assign busy     = !idle;
    assign sweep_we = (state_q == ST_SWEEP) && (cnt_q < DEPTH_CNT);

    // Memory write mux: sweep writes zero, host write passes when idle.
    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = host_addr;
        mem_wdata = host_wdata;
        if (sweep_we) begin
            mem_we    = 1'b1;
            mem_waddr = cnt_q[AW-1:0];
            mem_wdata = '0;
        end else if (idle && !cmd_clear && host_wr) begin
            mem_we    = 1'b1;
        end
    end

    // State and sweep counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (cmd_clear)                state_q <= ST_SWEEP;
                    else if (host_wr || host_rd)  state_q <= ST_ACC;
                end
                ST_ACC: state_q <= ST_IDLE;
                ST_SWEEP: begin
                    if (cnt_q == LAST_CNT) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q   <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Read data capture on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_rdata <= '0;
        else if (idle && !cmd_clear && !host_wr && host_rd)
            host_rdata <= mem_rdata;
    end

    // Sticky error on any request while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (busy && (host_wr || host_rd || cmd_clear))
            err <= 1'b1;
    end

    // R4: an accepted clear makes the block busy on the next cycle.
    p_clear_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_clear) |=> busy);

    // R4: the sweep counter never passes the fixed sweep length.
    p_sweep_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWEEP) |-> (cnt_q <= LAST_CNT));

    // R6: a request while busy raises the error flag.
    p_busy_req_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (host_wr || host_rd)) |=> err);

    // R6: the error flag is sticky.
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R8: a single access keeps busy for one cycle only.
    p_acc_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACC) |=> !busy);

    // R8: host read data changes only after an accepted read.
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(host_rdata));

endmodule

// File: rtl/ts_oe_gen.sv
// Output enable generator: on each bit strobe, picks the entry bit that
// covers the current quarter of the slot and registers it as pin_oe.
// Assumes SLOT_BITS is a multiple of ENTRY_W; bit index 0 is sent first
// and maps to the entry's most significant bit.
module ts_oe_gen #(
    parameter int ENTRY_W   = 4,
    parameter int SLOT_BITS = 8,
    localparam int BW       = $clog2(SLOT_BITS),
    localparam int SEG      = SLOT_BITS / ENTRY_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               drv_en,
    input  logic               bit_strobe,
    input  logic [BW-1:0]      bit_idx,
    input  logic [ENTRY_W-1:0] entry,
    output logic               pin_oe
);

    logic sel_bit;

    // Quarter select: entry bit covering the current bit position.
    always_comb begin
        sel_bit = 1'b0;
        for (int i = 0; i < ENTRY_W; i++) begin
            if ((32'(bit_idx) / SEG) == i) sel_bit = entry[ENTRY_W-1-i];
        end
    end

    // Registered enable, updated on bit boundaries, forced off when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)          pin_oe <= 1'b0;
        else if (!drv_en)    pin_oe <= 1'b0;
        else if (bit_strobe) pin_oe <= sel_bit;
    end

    // R5: global disable forces the output off on the next edge.
    p_disable_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |=> !pin_oe);

    // R7: without a strobe the enable holds its value.
    p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && !bit_strobe) |=> $stable(pin_oe));

endmodule

// File: rtl/ts_oe_ctrl.sv
// Top: per-timeslot output tristate controller. Connects the control
// memory, the host/sweep sequencer and the output enable generator.
// Assumes slot_idx/bit_idx come from an external frame counter and that
// bit_strobe marks each bit boundary for one cycle.
module ts_oe_ctrl #(
    parameter int NUM_SLOTS   = 32,
    parameter int ENTRY_W     = 4,
    parameter int SLOT_BITS   = 8,
    parameter int INIT_CYCLES = 1035,
    localparam int AW         = $clog2(NUM_SLOTS),
    localparam int BW         = $clog2(SLOT_BITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [AW-1:0]      host_addr,
    input  logic [ENTRY_W-1:0] host_wdata,
    output logic [ENTRY_W-1:0] host_rdata,
    input  logic               cmd_clear,
    output logic               busy,
    output logic               err,
    input  logic               drv_en,
    input  logic [AW-1:0]      slot_idx,
    input  logic [BW-1:0]      bit_idx,
    input  logic               bit_strobe,
    output logic               pin_oe
);

    logic               mem_we;
    logic [AW-1:0]      mem_waddr;
    logic [ENTRY_W-1:0] mem_wdata;
    logic [ENTRY_W-1:0] host_entry;
    logic [ENTRY_W-1:0] slot_entry;

    ts_ctl_mem #(
        .DEPTH   (NUM_SLOTS),
        .ENTRY_W (ENTRY_W)
    ) u_mem (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (host_addr),
        .rdata_a (host_entry),
        .raddr_b (slot_idx),
        .rdata_b (slot_entry)
    );

    ts_seq #(
        .DEPTH       (NUM_SLOTS),
        .ENTRY_W     (ENTRY_W),
        .INIT_CYCLES (INIT_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .cmd_clear  (cmd_clear),
        .mem_rdata  (host_entry),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .err        (err)
    );

    ts_oe_gen #(
        .ENTRY_W   (ENTRY_W),
        .SLOT_BITS (SLOT_BITS)
    ) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .drv_en     (drv_en),
        .bit_strobe (bit_strobe),
        .bit_idx    (bit_idx),
        .entry      (slot_entry),
        .pin_oe     (pin_oe)
    );

    // R6: the memory is never written by the host path while busy.
    p_no_host_write_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr && (host_addr != mem_waddr)) |-> !mem_we || (mem_wdata == '0));

endmodule

// File: tb/test_ts_oe_ctrl.sv
// Bench: sweeps all slots, all bit positions and several entry patterns.
// Expected values are computed arithmetically from the requirements.
module test_ts_oe_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NS  = 32;
    localparam int LEN = 1035;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0, cmd_clear = 1'b0;
    logic [4:0] host_addr = '0;
    logic [3:0] host_wdata = '0;
    logic [3:0] host_rdata;
    logic       busy, err;
    logic       drv_en = 1'b0;
    logic [4:0] slot_idx = '0;
    logic [2:0] bit_idx = '0;
    logic       bit_strobe = 1'b0;
    logic       pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ts_oe_ctrl i_ts_oe_ctrl (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cmd_clear(cmd_clear), .busy(busy), .err(err), .drv_en(drv_en),
        .slot_idx(slot_idx), .bit_idx(bit_idx), .bit_strobe(bit_strobe),
        .pin_oe(pin_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] pat(input int s, input int k);
        return 4'((s * 7 + k * 5 + 3) % 16);
    endfunction

    // Single write, checking the one-cycle busy (R8).
    task automatic wr(input int a, input logic [3:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 5'(a); host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        chk(busy == 1'b1, "R8", int'(busy), 1);
        @(negedge clk);
        chk(busy == 1'b0, "R8", int'(busy), 0);
    endtask

    task automatic rd(input int a, output logic [3:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = 5'(a);
        @(negedge clk);
        host_rd = 1'b0;
        @(negedge clk);
        d = host_rdata;
    endtask

    // Bulk clear; returns measured busy length (R4).
    task automatic do_clear(output int n);
        @(negedge clk);
        cmd_clear = 1'b1;
        @(negedge clk);
        cmd_clear = 1'b0;
        n = 0;
        while (busy && n < LEN + 10) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Strobe one bit position and return the resulting enable.
    task automatic strobe(input int s, input int b, output logic oe);
        @(negedge clk);
        slot_idx = 5'(s); bit_idx = 3'(b); bit_strobe = 1'b1;
        @(negedge clk);
        bit_strobe = 1'b0;
        oe = pin_oe;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        chk(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [3:0] d;
        logic oe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R3)
        chk(busy == 0 && err == 0 && pin_oe == 0 && host_rdata == 0, "R3 reset state",
            int'({busy, err, pin_oe}), 0);

        // Bulk clear length and result (R4)
        do_clear(n);
        chk(n == LEN, "R4 busy length", n, LEN);
        for (int s = 0; s < NS; s++) begin
            rd(s, d);
            chk(d == 4'h0, "R4 cleared entry", int'(d), 0);
        end

        // Write patterns and read back (R8)
        for (int s = 0; s < NS; s++) wr(s, pat(s, 0));
        for (int s = 0; s < NS; s++) begin
            rd(s, d);
            chk(d == pat(s, 0), "R8 readback", int'(d), int'(pat(s, 0)));
        end
        // rdata holds without a read (R8)
        repeat (3) @(negedge clk);
        chk(host_rdata == pat(NS-1, 0), "R8 rdata hold", int'(host_rdata), int'(pat(NS-1, 0)));

        // Full slot/bit sweep of enables for two patterns (R1)
        drv_en = 1'b1;
        for (int k = 0; k < 2; k++) begin
            if (k == 1) for (int s = 0; s < NS; s++) wr(s, pat(s, 1));
            for (int s = 0; s < NS; s++) begin
                for (int b = 0; b < 8; b++) begin
                    strobe(s, b, oe);
                    chk(oe == pat(s, k)[3 - b/2], "R1 quarter select", int'(oe),
                        int'(pat(s, k)[3 - b/2]));
                end
            end
        end

        // All-off and all-on entries (R2)
        wr(3, 4'h0); wr(4, 4'hF);
        for (int b = 0; b < 8; b++) begin
            strobe(3, b, oe);
            chk(oe == 1'b0, "R2 zero entry", int'(oe), 0);
            strobe(4, b, oe);
            chk(oe == 1'b1, "R2 full entry", int'(oe), 1);
        end

        // Hold between strobes (R7): slot 4 on; move to slot 3 without strobe
        strobe(4, 0, oe);
        @(negedge clk);
        slot_idx = 5'd3; bit_idx = 3'd0;
        repeat (3) @(negedge clk);
        chk(pin_oe == 1'b1, "R7 hold without strobe", int'(pin_oe), 1);
        bit_strobe = 1'b1;
        @(negedge clk);
        bit_strobe = 1'b0;
        chk(pin_oe == 1'b0, "R7 update on strobe", int'(pin_oe), 0);

        // Global disable (R5)
        strobe(4, 2, oe);
        drv_en = 1'b0;
        @(negedge clk);
        chk(pin_oe == 1'b0, "R5 disable next edge", int'(pin_oe), 0);
        for (int b = 0; b < 8; b++) begin
            strobe(4, b, oe);
            chk(oe == 1'b0, "R5 disabled strobe", int'(oe), 0);
        end
        drv_en = 1'b1;

        // Reset persistence (R3)
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pin_oe == 0 && busy == 0, "R3 outputs after reset", int'(pin_oe), 0);
        rd(4, d);
        chk(d == 4'hF, "R3 entry kept", int'(d), 15);
        rd(10, d);
        chk(d == pat(10, 1), "R3 entry kept", int'(d), int'(pat(10, 1)));

        // Request during sweep ignored, sticky error (R6)
        @(negedge clk);
        cmd_clear = 1'b1;
        @(negedge clk);
        cmd_clear = 1'b0;
        chk(err == 1'b0, "R6 err before", int'(err), 0);
        repeat (40) @(negedge clk);
        host_wr = 1'b1; host_addr = 5'd5; host_wdata = 4'hA;
        @(negedge clk);
        host_wr = 1'b0;
        @(negedge clk);
        chk(err == 1'b1, "R6 err set", int'(err), 1);
        while (busy) @(negedge clk);
        rd(5, d);
        chk(d == 4'h0, "R6 write ignored", int'(d), 0);
        // Read while busy leaves rdata unchanged
        wr(6, 4'h9);
        rd(6, d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 5'd7; host_wdata = 4'h3;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b1; host_addr = 5'd7;
        @(negedge clk);
        host_rd = 1'b0;
        @(negedge clk);
        chk(host_rdata == 4'h9, "R6 read ignored", int'(host_rdata), 9);
        chk(err == 1'b1, "R6 err sticky", int'(err), 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(err == 1'b0, "R6 err cleared by reset", int'(err), 0);

        // Priority (R9): clear beats write
        @(negedge clk);
        cmd_clear = 1'b1; host_wr = 1'b1; host_addr = 5'd7; host_wdata = 4'hC;
        @(negedge clk);
        cmd_clear = 1'b0; host_wr = 1'b0;
        n = 0;
        while (busy && n < LEN + 10) begin
            n++;
            @(negedge clk);
        end
        chk(n == LEN, "R9 clear wins length", n, LEN);
        rd(7, d);
        chk(d == 4'h0, "R9 clear wins data", int'(d), 0);
        // Write beats read
        rd(2, d);
        @(negedge clk);
        host_wr = 1'b1; host_rd = 1'b1; host_addr = 5'd8; host_wdata = 4'h6;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        @(negedge clk);
        chk(host_rdata == 4'h0, "R9 read dropped", int'(host_rdata), 0);
        chk(err == 1'b0, "R9 no error", int'(err), 0);
        rd(8, d);
        chk(d == 4'h6, "R9 write wins", int'(d), 6);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule